// File: doc/BRIEF.md
# Register-Pair Word Arithmetic Unit

This unit performs 16-bit arithmetic on a register pair built from an 8-bit high register (Y) and an 8-bit low register (A), working against a 16-bit operand word fetched from memory. It offers add word, subtract word, compare word, increment and decrement of the memory word, a load of the pair from the operand, and an unsigned 8x8 multiply of Y by A into the pair. Flags N, V, H, Z and C are updated according to the operation. Any flag an operation does not name passes through from the flag input.

The surrounding core presents the pair, the operand, the current flags and an operation code with a one-cycle `in_valid` strobe. One clock later the unit presents the new pair, the new memory word and the new flags, with write-enable outputs that say which destination the core should update. Memory sequencing and instruction decode belong to the surrounding core. The byte width is a parameter, so the same unit serves any even half width of at least four bits. Parameters also select a split or a single-carry adder and a shift-add or operator multiplier.

Top module: `pairalu_word`

## Requirements
- R1: Operation code 0 (add word) sets `pair_out` to (`pair_in` + `operand_in`) mod 2^16 with no carry-in, asserts `pair_we`, and sets C (flag bit 0) to the carry out of bit 15.
- R2: Operation code 1 (subtract word) sets `pair_out` to (`pair_in` - `operand_in`) mod 2^16, formed as the pair plus the two's complement of the operand, asserts `pair_we`, and sets C to 1 exactly when no borrow occurs (`pair_in` >= `operand_in`).
- R3: For add word and subtract word, H (flag bit 2) is the carry from bit 11 into bit 12 of the sum, and V (flag bit 3) is the signed two's-complement overflow of the high-byte addition, which equals the 16-bit signed overflow.
- R4: For every operation except code 7, N (flag bit 4) is bit 15 of the 16-bit result and Z (flag bit 1) is 1 only when all 16 result bits are zero.
- R5: Operation code 2 (compare word) computes `pair_in` - `operand_in`, updates only N, Z and C (C=1 means no borrow), and asserts neither `pair_we` nor `mem_we`, so V and H pass through unchanged.
- R6: Operation codes 3 (increment word) and 4 (decrement word) set `mem_out` to `operand_in` + 1 or - 1 mod 2^16, with the carry propagating from the low byte to the high byte, assert `mem_we` but not `pair_we`, and leave C, V and H unchanged.
- R7: Operation code 5 (load pair) sets `pair_out` to `operand_in`, asserts `pair_we`, and changes only N and Z.
- R8: Operation code 6 (multiply) sets `pair_out` to the unsigned product of `pair_in[15:8]` and `pair_in[7:0]`, with the high byte in Y and the low byte in A, asserts `pair_we`, and changes only N and Z.
- R9: Operation code 7 (no operation) asserts neither write enable and returns `flags_in` unchanged. For every operation, `pair_out` equals `pair_in` when `pair_we` is low, and `mem_out` equals `operand_in` when `mem_we` is low.
- R10: `out_valid` rises exactly one cycle after an accepted `in_valid` and is low otherwise. While `in_valid` is low, the result outputs and `flags_out` hold their last values. Reset clears every output to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Accept the operation this cycle |
| op_sel | input | 3 | Operation code (0 add, 1 sub, 2 cmp, 3 inc, 4 dec, 5 load, 6 mul, 7 none) |
| pair_in | input | 16 | Current pair, Y in the upper byte, A in the lower |
| operand_in | input | 16 | Memory word operand |
| flags_in | input | 5 | Current flags {N,V,H,Z,C}, bit 4 down to bit 0 |
| out_valid | output | 1 | Result valid |
| pair_out | output | 16 | New pair value |
| pair_we | output | 1 | Pair must be written back |
| mem_out | output | 16 | New memory word |
| mem_we | output | 1 | Memory word must be written back |
| flags_out | output | 5 | New flags {N,V,H,Z,C} |

## Verification
The assertions take for granted that `in_valid`, `op_sel` and the data inputs carry known values on every clock edge once reset is released. They also assume that reset is held from time zero, so that each `$past` comparison looks back only at cycles that were driven. Every one of the eight operation codes is legal, so no code has to be excluded. The stimulus changes inputs only on the falling edge and keeps them defined through reset. It pulses `in_valid` for single cycles, and it reaches the carry, borrow, half-carry, overflow and wrap boundaries through directed operands, then through a pseudo-random sweep across all codes.

// File: rtl/pairalu_pkg.sv
`timescale 1ns/1ps
package pairalu_pkg;

   typedef enum logic [2:0] {
      OP_ADDW = 3'd0,
      OP_SUBW = 3'd1,
      OP_CMPW = 3'd2,
      OP_INCW = 3'd3,
      OP_DECW = 3'd4,
      OP_LDW  = 3'd5,
      OP_MULW = 3'd6,
      OP_NOP  = 3'd7
   } pair_op_e;

   typedef struct packed {
      logic neg;
      logic ovf;
      logic half;
      logic zero;
      logic carry;
   } pair_flags_t;

   localparam int FLAG_W = $bits(pair_flags_t);

endpackage

// File: rtl/pairalu_addw.sv
`timescale 1ns/1ps
module pairalu_addw #(
   parameter int HALF_W = 8,
   parameter bit SPLIT  = 1'b1
) (
   input  logic [2*HALF_W-1:0] opa,
   input  logic [2*HALF_W-1:0] opb,
   input  logic                cin,
   output logic [2*HALF_W-1:0] sum,
   output logic                cout,
   output logic                hcarry,
   output logic                ovf
);
   localparam int WORD_W = 2 * HALF_W;
   localparam int MSB    = WORD_W - 1;
   localparam int HC_BIT = HALF_W + HALF_W / 2;

   generate
      if (SPLIT) begin : g_split
         logic [HALF_W:0] lo_s;
         logic [HALF_W:0] hi_s;
         assign lo_s = {1'b0, opa[HALF_W-1:0]} + {1'b0, opb[HALF_W-1:0]}
                     + {{HALF_W{1'b0}}, cin};
         assign hi_s = {1'b0, opa[MSB:HALF_W]} + {1'b0, opb[MSB:HALF_W]}
                     + {{HALF_W{1'b0}}, lo_s[HALF_W]};
         assign sum  = {hi_s[HALF_W-1:0], lo_s[HALF_W-1:0]};
         assign cout = hi_s[HALF_W];
      end else begin : g_flat
         logic [WORD_W:0] w_s;
         assign w_s  = {1'b0, opa} + {1'b0, opb} + {{WORD_W{1'b0}}, cin};
         assign sum  = w_s[MSB:0];
         assign cout = w_s[WORD_W];
      end
   endgenerate

   // carry into the middle bit of the high byte
   assign hcarry = opa[HC_BIT] ^ opb[HC_BIT] ^ sum[HC_BIT];
   // signed overflow of the high-byte add
   assign ovf    = (opa[MSB] == opb[MSB]) && (sum[MSB] != opa[MSB]);

endmodule

// File: rtl/pairalu_mul.sv
`timescale 1ns/1ps
module pairalu_mul #(
   parameter int HALF_W = 8,
   parameter bit SHIFT_ADD = 1'b1
) (
   input  logic [HALF_W-1:0]   mcand,
   input  logic [HALF_W-1:0]   mplier,
   output logic [2*HALF_W-1:0] prod
);
   localparam int WORD_W = 2 * HALF_W;

   generate
      if (SHIFT_ADD) begin : g_shift_add
         logic [WORD_W-1:0] pp [HALF_W];
         logic [WORD_W-1:0] acc;
         for (genvar g = 0; g < HALF_W; g++) begin : g_pp
            assign pp[g] = mplier[g] ? ({{HALF_W{1'b0}}, mcand} << g) : '0;
         end
         always_comb begin
            acc = '0;
            for (int k = 0; k < HALF_W; k++) acc = acc + pp[k];
         end
         assign prod = acc;
      end else begin : g_operator
         assign prod = {{HALF_W{1'b0}}, mcand} * {{HALF_W{1'b0}}, mplier};
      end
   endgenerate

endmodule

// File: rtl/pairalu_flags.sv
`timescale 1ns/1ps
module pairalu_flags
   import pairalu_pkg::*;
#(
   parameter int WORD_W = 16
) (
   input  pair_op_e          op,
   input  pair_flags_t       fin,
   input  logic [WORD_W-1:0] result,
   input  logic              cout,
   input  logic              hcarry,
   input  logic              ovf,
   output pair_flags_t       fout
);
   logic res_zero;
   logic res_neg;

   assign res_zero = ~|result;
   assign res_neg  = result[WORD_W-1];

   always_comb begin
      fout = fin;
      unique case (op)
         OP_ADDW, OP_SUBW: begin
            fout.neg   = res_neg;
            fout.zero  = res_zero;
            fout.carry = cout;
            fout.half  = hcarry;
            fout.ovf   = ovf;
         end
         OP_CMPW: begin
            fout.neg   = res_neg;
            fout.zero  = res_zero;
            fout.carry = cout;
         end
         OP_INCW, OP_DECW, OP_LDW, OP_MULW: begin
            fout.neg   = res_neg;
            fout.zero  = res_zero;
         end
         default: fout = fin;
      endcase
   end

endmodule

// File: rtl/pairalu_word.sv
`timescale 1ns/1ps
module pairalu_word
   import pairalu_pkg::*;
#(
   parameter int HALF_W      = 8,
   parameter bit SPLIT_ADDER = 1'b1,
   parameter bit MUL_SHIFT   = 1'b1,
   localparam int WORD_W     = 2 * HALF_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [2:0]        op_sel,
   input  logic [WORD_W-1:0] pair_in,
   input  logic [WORD_W-1:0] operand_in,
   input  logic [4:0]        flags_in,
   output logic              out_valid,
   output logic [WORD_W-1:0] pair_out,
   output logic              pair_we,
   output logic [WORD_W-1:0] mem_out,
   output logic              mem_we,
   output logic [4:0]        flags_out
);

   generate
      if ((HALF_W < 4) || (HALF_W % 2 != 0)) begin : g_bad_width
         $error("pairalu_word: HALF_W must be even and at least 4");
      end
      if (FLAG_W != 5) begin : g_bad_flags
         $error("pairalu_word: flag record must be five bits");
      end
   endgenerate

   pair_op_e          op;
   logic              is_sub;
   logic              is_step;
   logic              pair_wr;
   logic              mem_wr;
   logic [WORD_W-1:0] add_a;
   logic [WORD_W-1:0] add_b;
   logic [WORD_W-1:0] add_sum;
   logic              add_cout;
   logic              add_hc;
   logic              add_ovf;
   logic [WORD_W-1:0] mul_prod;
   logic [WORD_W-1:0] result;
   pair_flags_t       flags_nx;

   assign op      = pair_op_e'(op_sel);
   assign is_sub  = (op == OP_SUBW) || (op == OP_CMPW);
   assign is_step = (op == OP_INCW) || (op == OP_DECW);
   assign pair_wr = (op == OP_ADDW) || (op == OP_SUBW) ||
                    (op == OP_LDW)  || (op == OP_MULW);
   assign mem_wr  = is_step;

   // one shared adder serves pair and memory word operations
   always_comb begin
      add_a = is_step ? operand_in : pair_in;
      if (op == OP_INCW)      add_b = {{(WORD_W-1){1'b0}}, 1'b1};
      else if (op == OP_DECW) add_b = '1;
      else if (is_sub)        add_b = ~operand_in;
      else                    add_b = operand_in;
   end

   pairalu_addw #(.HALF_W(HALF_W), .SPLIT(SPLIT_ADDER)) adder_i (
      .opa    (add_a),
      .opb    (add_b),
      .cin    (is_sub),
      .sum    (add_sum),
      .cout   (add_cout),
      .hcarry (add_hc),
      .ovf    (add_ovf)
   );

   pairalu_mul #(.HALF_W(HALF_W), .SHIFT_ADD(MUL_SHIFT)) mul_i (
      .mcand  (pair_in[WORD_W-1:HALF_W]),
      .mplier (pair_in[HALF_W-1:0]),
      .prod   (mul_prod)
   );

   always_comb begin
      unique case (op)
         OP_LDW:  result = operand_in;
         OP_MULW: result = mul_prod;
         default: result = add_sum;
      endcase
   end

   pairalu_flags #(.WORD_W(WORD_W)) flags_i (
      .op     (op),
      .fin    (pair_flags_t'(flags_in)),
      .result (result),
      .cout   (add_cout),
      .hcarry (add_hc),
      .ovf    (add_ovf),
      .fout   (flags_nx)
   );

   pair_op_e op_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         op_q      <= OP_NOP;
         pair_out  <= '0;
         pair_we   <= 1'b0;
         mem_out   <= '0;
         mem_we    <= 1'b0;
         flags_out <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            op_q      <= op;
            pair_out  <= pair_wr ? result : pair_in;
            pair_we   <= pair_wr;
            mem_out   <= mem_wr ? result : operand_in;
            mem_we    <= mem_wr;
            flags_out <= flags_nx;
         end
      end
   end

   // R10
   valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == $past(in_valid));

   // R5
   cmp_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && op_q == OP_CMPW) |-> (!pair_we && !mem_we));

   // R5
   cmp_keep_vh_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op_sel == OP_CMPW) |=> (flags_out[3:2] == $past(flags_in[3:2])));

   // R6
   step_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && (op_sel == OP_INCW || op_sel == OP_DECW)) |=>
      (flags_out[3:2] == $past(flags_in[3:2]) && flags_out[0] == $past(flags_in[0])
       && pair_out == $past(pair_in) && mem_we && !pair_we));

   // R4
   nz_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && pair_we) |->
      (flags_out[1] == (pair_out == '0) && flags_out[4] == pair_out[WORD_W-1]));

   // R4
   nz_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && mem_we) |->
      (flags_out[1] == (mem_out == '0) && flags_out[4] == mem_out[WORD_W-1]));

   // R9
   nop_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op_sel == OP_NOP) |=>
      (flags_out == $past(flags_in) && !pair_we && !mem_we));

   // R7
   load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op_sel == OP_LDW) |=>
      (pair_out == $past(operand_in) && flags_out[3:2] == $past(flags_in[3:2])));

   // R8
   mul_prod_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op_sel == OP_MULW) |=>
      (pair_out == (WORD_W'($past(pair_in[WORD_W-1:HALF_W])) *
                    WORD_W'($past(pair_in[HALF_W-1:0])))));

endmodule

// File: tb/pairalu_word_tb_top.sv
`timescale 1ns/1ps
module pairalu_word_tb_top;

   localparam real CLK_HALF = 2.5;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [2:0]  op_sel = 3'd7;
   logic [15:0] pair_in = '0;
   logic [15:0] operand_in = '0;
   logic [4:0]  flags_in = '0;
   logic        out_valid;
   logic [15:0] pair_out;
   logic        pair_we;
   logic [15:0] mem_out;
   logic        mem_we;
   logic [4:0]  flags_out;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #(CLK_HALF) clk = ~clk;

   pairalu_word dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
      .pair_in(pair_in), .operand_in(operand_in), .flags_in(flags_in),
      .out_valid(out_valid), .pair_out(pair_out), .pair_we(pair_we),
      .mem_out(mem_out), .mem_we(mem_we), .flags_out(flags_out)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic int sx16(input int v);
      return (v >= 32768) ? v - 65536 : v;
   endfunction

   // reference model written from the requirements
   task automatic model(input logic [2:0] op, input logic [15:0] p,
                        input logic [15:0] o, input logic [4:0] fi,
                        output logic [15:0] ep, output logic epw,
                        output logic [15:0] em, output logic emw,
                        output logic [4:0] ef);
      int pi = int'(p);
      int oi = int'(o);
      int r  = 0;
      int sv;
      ep = p; em = o; epw = 1'b0; emw = 1'b0; ef = fi;
      case (op)
         3'd0: begin
            r = (pi + oi) & 16'hFFFF;
            ef[0] = (pi + oi) > 65535;
            ef[2] = ((pi & 12'hFFF) + (oi & 12'hFFF)) > 4095;
            sv = sx16(pi) + sx16(oi);
            ef[3] = (sv > 32767) || (sv < -32768);
            ep = r[15:0]; epw = 1'b1;
         end
         3'd1, 3'd2: begin
            r = (pi - oi) & 16'hFFFF;
            ef[0] = pi >= oi;
            if (op == 3'd1) begin
               ef[2] = ((pi & 12'hFFF) + ((~oi) & 12'hFFF) + 1) > 4095;
               sv = sx16(pi) - sx16(oi);
               ef[3] = (sv > 32767) || (sv < -32768);
               ep = r[15:0]; epw = 1'b1;
            end
         end
         3'd3: begin r = (oi + 1) & 16'hFFFF; em = r[15:0]; emw = 1'b1; end
         3'd4: begin r = (oi - 1) & 16'hFFFF; em = r[15:0]; emw = 1'b1; end
         3'd5: begin r = oi; ep = o; epw = 1'b1; end
         3'd6: begin r = (pi >> 8) * (pi & 255); ep = r[15:0]; epw = 1'b1; end
         default: ;
      endcase
      if (op != 3'd7) begin
         ef[4] = r[15];
         ef[1] = (r == 0);
      end
   endtask

   task automatic run_case(input string req, input logic [2:0] op,
                           input logic [15:0] p, input logic [15:0] o,
                           input logic [4:0] fi);
      logic [15:0] ep, em;
      logic        epw, emw;
      logic [4:0]  ef;
      model(op, p, o, fi, ep, epw, em, emw, ef);
      @(negedge clk);
      in_valid = 1'b1; op_sel = op; pair_in = p; operand_in = o; flags_in = fi;
      @(negedge clk);
      in_valid = 1'b0;
      chk(req, "out_valid", 32'(out_valid), 32'd1);
      chk(req, "pair_out",  32'(pair_out),  32'(ep));
      chk(req, "pair_we",   32'(pair_we),   32'(epw));
      chk(req, "mem_out",   32'(mem_out),   32'(em));
      chk(req, "mem_we",    32'(mem_we),    32'(emw));
      chk(req, "flags_out", 32'(flags_out), 32'(ef));
   endtask

   task automatic t_reset;
      chk("R10", "reset out_valid", 32'(out_valid), 32'd0);
      chk("R10", "reset pair_out",  32'(pair_out),  32'd0);
      chk("R10", "reset mem_out",   32'(mem_out),   32'd0);
      chk("R10", "reset flags_out", 32'(flags_out), 32'd0);
      chk("R10", "reset we", 32'({pair_we, mem_we}), 32'd0);
   endtask

   task automatic t_add;
      run_case("R1", 3'd0, 16'h1234, 16'h1111, 5'b00000);
      run_case("R1", 3'd0, 16'hFFFF, 16'h0001, 5'b00000); // wrap, C, Z, H
      run_case("R3", 3'd0, 16'h7F00, 16'h0100, 5'b00000); // V, N
      run_case("R3", 3'd0, 16'h0800, 16'h0800, 5'b00000); // H only
      run_case("R3", 3'd0, 16'h8000, 16'h8000, 5'b11111); // negative overflow
   endtask

   task automatic t_sub;
      run_case("R2", 3'd1, 16'h1234, 16'h1234, 5'b00000); // zero, no borrow
      run_case("R2", 3'd1, 16'h0000, 16'h0001, 5'b00000); // borrow
      run_case("R2", 3'd1, 16'h5555, 16'h0000, 5'b00000); // zero operand, C=1
      run_case("R3", 3'd1, 16'h8000, 16'h0001, 5'b00000); // signed overflow
      run_case("R3", 3'd1, 16'h1000, 16'h0001, 5'b11111); // half borrow
   endtask

   task automatic t_cmp;
      run_case("R5", 3'd2, 16'h1000, 16'h2000, 5'b01101); // V,H preserved
      run_case("R5", 3'd2, 16'hABCD, 16'hABCD, 5'b01100);
      run_case("R5", 3'd2, 16'h8000, 16'h0001, 5'b00000);
   endtask

   task automatic t_step;
      run_case("R6", 3'd3, 16'hFFFF, 16'hFFFF, 5'b01101); // inc to zero
      run_case("R6", 3'd3, 16'h4321, 16'h00FF, 5'b00000); // low-byte carry
      run_case("R6", 3'd4, 16'h0000, 16'h0000, 5'b01101); // dec to all ones
      run_case("R6", 3'd4, 16'h0000, 16'h0100, 5'b00010); // low-byte borrow
   endtask

   task automatic t_load;
      run_case("R7", 3'd5, 16'h1111, 16'h8000, 5'b01101);
      run_case("R7", 3'd5, 16'h1111, 16'h0000, 5'b10000);
   endtask

   task automatic t_mul;
      run_case("R8", 3'd6, 16'hFFFF, 16'h0000, 5'b01101);
      run_case("R8", 3'd6, 16'h0012, 16'h0000, 5'b00000); // zero product
      run_case("R8", 3'd6, 16'h0C0B, 16'h0000, 5'b00000);
   endtask

   task automatic t_nop;
      run_case("R9", 3'd7, 16'h1357, 16'h2468, 5'b10101);
      run_case("R9", 3'd7, 16'h0000, 16'hFFFF, 5'b01010);
   endtask

   task automatic t_hold;
      logic [4:0]  f_prev;
      logic [15:0] p_prev;
      run_case("R10", 3'd0, 16'h0001, 16'h0002, 5'b11111);
      f_prev = flags_out;
      p_prev = pair_out;
      flags_in = 5'b00000; pair_in = 16'hDEAD; op_sel = 3'd5;
      @(negedge clk);
      chk("R10", "idle out_valid", 32'(out_valid), 32'd0);
      chk("R10", "idle flags hold", 32'(flags_out), 32'(f_prev));
      chk("R10", "idle pair hold",  32'(pair_out),  32'(p_prev));
   endtask

   task automatic t_sweep;
      logic [31:0] lfsr = 32'hACE1_2468;
      for (int i = 0; i < 64; i++) begin
         lfsr = lfsr ^ (lfsr << 13);
         lfsr = lfsr ^ (lfsr >> 17);
         lfsr = lfsr ^ (lfsr << 5);
         case (i % 8)
            0: run_case("R1", 3'd0, lfsr[15:0], lfsr[31:16], lfsr[4:0]);
            1: run_case("R2", 3'd1, lfsr[15:0], lfsr[31:16], lfsr[4:0]);
            2: run_case("R5", 3'd2, lfsr[15:0], lfsr[31:16], lfsr[4:0]);
            3: run_case("R6", 3'd3, lfsr[15:0], lfsr[31:16], lfsr[4:0]);
            4: run_case("R6", 3'd4, lfsr[15:0], lfsr[31:16], lfsr[4:0]);
            5: run_case("R7", 3'd5, lfsr[15:0], lfsr[31:16], lfsr[4:0]);
            6: run_case("R8", 3'd6, lfsr[15:0], lfsr[31:16], lfsr[4:0]);
            default: run_case("R9", 3'd7, lfsr[15:0], lfsr[31:16], lfsr[4:0]);
         endcase
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_add();
      t_sub();
      t_cmp();
      t_step();
      t_load();
      t_mul();
      t_nop();
      t_hold();
      t_sweep();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      #(2.0 * CLK_HALF * 100000.0);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL R10 watchdog actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

endmodule